// File: doc/BRIEF.md
# Registered Gray-Code Up/Down Counter

This block is a parameterised counter of width `W` that holds a binary count and a Gray-coded copy of the same count, each in its own register bank. Each Gray bit is formed from the binary register's next-state value, not from its current output. Both banks therefore load on the same clock edge and always show the same count, and no decode logic sits between the flops and the Gray output.

An enable input gates counting and a direction input selects increment or decrement. The count wraps at both ends. The Gray output is a clean registered value that moves by exactly one bit per step, so it suits pointers that other logic samples. The binary value is a second output at no extra cost.

Top module: `gray_cnt`

## Requirements
- R1: While `rst_ni` is low, `bin_o` and `gray_o` are both all zeros. Reset is asynchronous and active low.
- R2: On every cycle, bit i of `gray_o` (i < W-1) equals `bin_o[i+1] ^ bin_o[i]`, and `gray_o[W-1]` equals `bin_o[W-1]`.
- R3: `bin_o` and `gray_o` change on the same rising clock edge, with no cycle of skew between them.
- R4: When `en_i` is low at a rising edge, neither output changes.
- R5: When `en_i` is high and `up_i` is 1 at a rising edge, `bin_o` increases by one modulo 2^W, so all ones is followed by zero.
- R6: When `en_i` is high and `up_i` is 0 at a rising edge, `bin_o` decreases by one modulo 2^W, so zero is followed by all ones.
- R7: Across every enabled edge, including both wrap-arounds, exactly one bit of `gray_o` changes.
- R8: The structure is correct for any `W` of at least 1, including the single-bit case, where `gray_o` equals `bin_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| up_i | input | 1 | Direction: 1 increments, 0 decrements |
| bin_o | output | W | Registered binary count |
| gray_o | output | W | Registered Gray count |

## Verification
The hardest states to reach are the wrap points: the step down from zero to all ones and the step up from all ones to zero. Around these points a single bit-flip rule is easy to break, and a skew between the two banks would also show. The stimulus reaches the downward wrap straight after reset. It also reverses direction at both ends and inserts disabled cycles right at the wrap. A second instance with a width of one covers the degenerate mapping. A cycle-by-cycle model compares both outputs on every clock while random enable and direction run.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/gray_cnt_next.sv
module gray_cnt_next
  import gray_cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_q_i,
  input  logic         en_i,
  input  cnt_dir_e     dir_i,
  output logic [W-1:0] bin_d_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    bin_d_o = bin_q_i;
    if (en_i) begin
      if (dir_i == DIR_UP) bin_d_o = bin_q_i + ONE;
      else                 bin_d_o = bin_q_i - ONE;
    end
  end
endmodule

// File: rtl/gray_cnt_enc.sv
module gray_cnt_enc #(
  parameter int W = 4
) (
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] gray_o
);
  localparam int MSB = W - 1;

  for (genvar i = 0; i < MSB; i++) begin : g_pair
    assign gray_o[i] = bin_i[i+1] ^ bin_i[i];
  end
  assign gray_o[MSB] = bin_i[MSB];
endmodule

// File: rtl/gray_cnt_reg.sv
module gray_cnt_reg #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/gray_cnt.sv
module gray_cnt
  import gray_cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         up_i,
  output logic [W-1:0] bin_o,
  output logic [W-1:0] gray_o
);
  logic [W-1:0] bin_q, bin_d, gray_d;
  cnt_dir_e     dir;

  assign dir = up_i ? DIR_UP : DIR_DOWN;

  gray_cnt_next #(.W(W)) u_next (
    .bin_q_i(bin_q), .en_i(en_i), .dir_i(dir), .bin_d_o(bin_d)
  );

  // encode from D, not Q, so both banks load the same count
  gray_cnt_enc #(.W(W)) u_enc (.bin_i(bin_d), .gray_o(gray_d));

  gray_cnt_reg #(.W(W)) u_bin_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bin_d), .q_o(bin_q)
  );

  gray_cnt_reg #(.W(W)) u_gray_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(gray_d), .q_o(gray_o)
  );

  assign bin_o = bin_q;
endmodule

// File: rtl/gray_cnt_chk.sv
module gray_cnt_chk #(
  parameter int W = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic         up_i,
  input logic [W-1:0] bin_o,
  input logic [W-1:0] gray_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  // R2 and R3: the two banks always carry the same count
  p_gray_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gray_o == (bin_o ^ (bin_o >> 1)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !en_i |=> $stable(bin_o) && $stable(gray_o));

  p_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && up_i |=> bin_o == $past(bin_o) + ONE);

  p_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i && !up_i |=> bin_o == $past(bin_o) - ONE);

  p_one_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && en_i |=> $countones(gray_o ^ $past(gray_o)) == 1);
endmodule

bind gray_cnt gray_cnt_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .up_i(up_i),
  .bin_o(bin_o), .gray_o(gray_o)
);

// File: tb/gray_cnt_bench.sv
module gray_cnt_bench;
  localparam int W = 4;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, up = 1'b1;
  logic [W-1:0] bin, gray;
  logic [0:0]   bin1, gray1;

  int n_chk = 0, n_err = 0;
  int m = 0, m1 = 0;
  int prev_g = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  gray_cnt #(.W(W)) u_gray_cnt (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .up_i(up),
    .bin_o(bin), .gray_o(gray)
  );

  gray_cnt #(.W(1)) u_gray_cnt_w1 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .up_i(up),
    .bin_o(bin1), .gray_o(gray1)
  );

  function automatic int to_gray(int v);
    return v ^ (v >> 1);
  endfunction

  function automatic int ones(int v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with the model; call at a falling edge
  task automatic compare(string req, bit stepped);
    chk({req, " bin"}, int'(bin), m);
    chk("R2 R3 gray", int'(gray), to_gray(m));
    chk("R8 w1 bin", int'(bin1), m1);
    chk("R8 w1 gray", int'(gray1), m1);
    if (stepped) chk("R7 one bit", ones(int'(gray) ^ prev_g), 1);
    prev_g = int'(gray);
  endtask

  // apply inputs for one edge, advance the model, check after the edge
  task automatic step(bit e, bit u, string req);
    en = e; up = u;
    if (e) begin
      m  = u ? (m + 1) % MOD : (m + MOD - 1) % MOD;
      m1 = u ? (m1 + 1) % 2 : (m1 + 1) % 2;
    end
    @(negedge clk);
    compare(req, e);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 bin", int'(bin), 0);
    chk("R1 gray", int'(gray), 0);
    chk("R1 w1", int'(bin1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after release", 0);
    // R6: downward wrap straight out of reset
    step(1, 0, "R6 wrap down");
    for (int i = 0; i < 3; i++) step(1, 0, "R6 down");
    // R5: full upward sweep through the wrap
    for (int i = 0; i < MOD + 4; i++) step(1, 1, "R5 up");
    // R4: hold at the top, then reverse at the wrap
    while (m != MOD - 1) step(1, 1, "R5 approach");
    for (int i = 0; i < 3; i++) step(0, 1, "R4 hold at top");
    step(1, 1, "R5 wrap up");
    step(0, 0, "R4 hold at zero");
    step(1, 0, "R6 wrap down again");
    step(1, 1, "R5 reverse");
    for (int i = 0; i < MOD + 2; i++) step(1, 0, "R6 down");
    // mixed random traffic
    for (int i = 0; i < 400; i++) step(1'($urandom % 4 != 0), 1'($urandom), "R4 R5 R6 mix");
    // R1: reset in mid-run
    while (m == 0) step(1, 1, "R5 leave zero");
    rst_n = 1'b0;
    #1;
    chk("R1 async bin", int'(bin), 0);
    chk("R1 async gray", int'(gray), 0);
    m = 0; m1 = 0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    compare("R1 held", 0);
    rst_n = 1'b1;
    step(1, 1, "R5 after reset");
    step(1, 1, "R5 after reset");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule